// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block holds the tag directory of a 32 KB data cache built from 64-byte lines arranged as 64 sets of 8 ways. A lookup brings two things. The first is the set index, which comes straight from untranslated address bits. The second is a 24-bit physical page number, which the translation unit produces in parallel with the index. All eight stored tags of the chosen set are compared at once. One clock later the block reports whether the lookup hit and which way matched. On a miss it also names the way that a refill should replace.

Each way carries a valid bit, and each set carries a 7-bit tree pseudo-LRU state. When a set still has an empty way, that empty way is offered as the victim. When the set is full, the tree picks the line to evict. A fill port installs a tag into a named way. A flush input sweeps the whole directory invalid, one set per clock.

Top module: `set_assoc_tag_dir`

## Requirements
- R1: The set index is address bits 11 down to 6, and the lookup and fill ports carry exactly those bits. For example, address 0x800010a0 selects set 2 with page tag 0x080001.
- R2: A lookup that is accepted raises rsp_valid on the next cycle. rsp_hit is 1 when some valid way of the set holds a tag equal to lk_ppn, and rsp_way then gives the lowest such way index.
- R3: On a miss, rsp_victim is the lowest-numbered invalid way of the set whenever one exists.
- R4: On a miss in a set whose 8 ways are all valid, rsp_victim comes from the set's pseudo-LRU tree. Node 0 is the root. Node n has children 2n+1 (covering the lower-numbered ways) and 2n+2. A node bit of 0 sends the victim to the lower half. The victim's bits, from the most significant down, are the node bits read along that path.
- R5: A hit, and likewise a fill, updates the tree of its set. Each node on the path to the way that was used is set so that it points away from that way. A miss leaves the tree unchanged.
- R6: An accepted fill writes fill_ppn into way fill_way (a 3-bit binary index) of its set and marks that way valid. A lookup on the next cycle sees the new tag.
- R7: When a fill and a lookup target the same set in the same cycle, the fill is performed and the lookup is dropped: rsp_valid is 0 on the next cycle.
- R8: A fill and a lookup to different sets in the same cycle both take effect. The lookup sees the directory as it was before that fill.
- R9: A flush pulse raises flush_busy for exactly 64 cycles. During the sweep every valid bit and every tree state is cleared. In the cycle the flush is raised and while flush_busy is high, lookups are dropped and fills are ignored.
- R10: After reset every way is invalid and every tree state is 0. rsp_valid, rsp_hit and flush_busy are 0.
- R11: rsp_hit is never 1 unless rsp_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 6 | Untranslated address bits 11:6 (set index) |
| lk_ppn | input | 24 | Translated physical page number to compare |
| fill_valid | input | 1 | Fill request |
| fill_vaddr | input | 6 | Address bits 11:6 of the fill |
| fill_way | input | 3 | Way to write |
| fill_ppn | input | 24 | Tag to install |
| flush | input | 1 | Starts an invalidate sweep |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 3 | Way that hit |
| rsp_victim | output | 3 | Way to refill on a miss |
| flush_busy | output | 1 | Sweep in progress |

## Verification
The case most likely to hide bugs is a fill and a lookup arriving in the same clock. The outcome depends on whether their set bits match. If they name the same set, the lookup must be dropped while the fill still lands. If they name different sets, both must proceed, and the two pseudo-LRU updates go to two different sets. The bench forces both cases with directed steps. It also mixes random fills and lookups over only four sets, so collisions occur often. A behavioural model compares every reported field on every clock, and that includes the victim choice that follows the colliding fill.

// File: rtl/set_assoc_tag_dir.sv
module set_assoc_tag_dir #(
  parameter int OFF_W  = 12,
  parameter int LINE_W = 6,
  parameter int TAG_W  = 24,
  parameter int WAYS   = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lk_valid,
  input  logic [OFF_W-1:LINE_W]   lk_vaddr,
  input  logic [TAG_W-1:0]        lk_ppn,
  input  logic                    fill_valid,
  input  logic [OFF_W-1:LINE_W]   fill_vaddr,
  input  logic [$clog2(WAYS)-1:0] fill_way,
  input  logic [TAG_W-1:0]        fill_ppn,
  input  logic                    flush,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [$clog2(WAYS)-1:0] rsp_way,
  output logic [$clog2(WAYS)-1:0] rsp_victim,
  output logic                    flush_busy
);
  localparam int IDX_W = OFF_W - LINE_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int NODES = WAYS - 1;

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [WAYS-1:0]  vld_q  [SETS];
  logic [NODES-1:0] plru_q [SETS];
  logic [IDX_W-1:0] sweep_ptr;

  logic [IDX_W-1:0] lk_set, fill_set;
  logic             blocked, lk_go, fill_go, hit_any, has_inv;
  logic [WAYS-1:0]  match, set_vld;
  logic [WAY_W-1:0] hit_way, inv_way;

  function automatic logic [WAY_W-1:0] tree_pick(logic [NODES-1:0] p);
    logic [WAY_W-1:0] v;
    int node;
    node = 0;
    v = '0;
    for (int l = 0; l < WAY_W; l++) begin
      v[WAY_W-1-l] = p[node];
      node = 2 * node + (p[node] ? 2 : 1);
    end
    return v;
  endfunction

  function automatic logic [NODES-1:0] tree_touch(logic [NODES-1:0] p, logic [WAY_W-1:0] w);
    logic [NODES-1:0] q;
    int node;
    q = p;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      q[node] = ~w[WAY_W-1-l];
      node = 2 * node + (w[WAY_W-1-l] ? 2 : 1);
    end
    return q;
  endfunction

  assign lk_set   = lk_vaddr;
  assign fill_set = fill_vaddr;
  assign blocked  = flush | flush_busy;
  assign lk_go    = lk_valid & ~blocked & ~(fill_valid & (fill_set == lk_set));
  assign fill_go  = fill_valid & ~blocked;
  assign set_vld  = vld_q[lk_set];
  assign hit_any  = |match;
  assign has_inv  = ~&set_vld;

  always_comb begin
    hit_way = '0;
    inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      match[w] = set_vld[w] && (tag_q[lk_set][w] == lk_ppn);
      if (match[w])    hit_way = WAY_W'(w);
      if (!set_vld[w]) inv_way = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
      flush_busy <= 1'b0;
      sweep_ptr  <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way    <= '0;
      rsp_victim <= '0;
    end else begin
      rsp_valid  <= lk_go;
      rsp_hit    <= lk_go & hit_any;
      rsp_way    <= hit_way;
      rsp_victim <= has_inv ? inv_way : tree_pick(plru_q[lk_set]);
      if (lk_go && hit_any)
        plru_q[lk_set] <= tree_touch(plru_q[lk_set], hit_way);
      if (fill_go) begin
        tag_q[fill_set][fill_way] <= fill_ppn;
        vld_q[fill_set][fill_way] <= 1'b1;
        plru_q[fill_set]          <= tree_touch(plru_q[fill_set], fill_way);
      end
      if (flush_busy) begin
        vld_q[sweep_ptr]  <= '0;
        plru_q[sweep_ptr] <= '0;
        sweep_ptr         <= sweep_ptr + 1'b1;
        if (sweep_ptr == IDX_W'(SETS - 1)) flush_busy <= 1'b0;
      end else if (flush) begin
        flush_busy <= 1'b1;
        sweep_ptr  <= '0;
      end
    end
  end
endmodule

// File: rtl/tag_dir_chk.sv
module tag_dir_chk #(
  parameter int IDX_W = 6,
  parameter int TAG_W = 24,
  parameter int SETS  = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic [IDX_W-1:0] lk_vaddr,
  input logic [TAG_W-1:0] lk_ppn,
  input logic             fill_valid,
  input logic [IDX_W-1:0] fill_vaddr,
  input logic [TAG_W-1:0] fill_ppn,
  input logic             flush,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             flush_busy
);
  int busy_len;
  always_ff @(posedge clk) begin
    if (!rst_n || !flush_busy) busy_len <= 0;
    else busy_len <= busy_len + 1;
  end

  logic same_set;
  assign same_set = fill_valid && (fill_vaddr == lk_vaddr);

  p_hit_needs_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !flush && !flush_busy && !same_set) |=> rsp_valid);

  p_fill_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && same_set) |=> !rsp_valid);

  p_sweep_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || flush_busy) |=> !rsp_valid);

  p_sweep_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush_busy) |-> (busy_len == SETS));

  p_fill_visible_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !flush && !flush_busy && !same_set &&
     $past(fill_valid && !flush && !flush_busy) &&
     lk_vaddr == $past(fill_vaddr) && lk_ppn == $past(fill_ppn)) |=> rsp_hit);

  p_sweep_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && $past(flush_busy) && !flush_busy && !flush && !same_set) |=> !rsp_hit);
endmodule

bind set_assoc_tag_dir tag_dir_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W), .SETS(SETS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_ppn(lk_ppn),
  .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_ppn(fill_ppn), .flush(flush),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .flush_busy(flush_busy));

// File: tb/test_set_assoc_tag_dir.sv
`timescale 1ns/1ps
module test_set_assoc_tag_dir;
  localparam int SETS = 64, WAYS = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, fill_valid = 1'b0, flush = 1'b0;
  logic [5:0]  lk_vaddr = '0, fill_vaddr = '0;
  logic [23:0] lk_ppn = '0, fill_ppn = '0;
  logic [2:0]  fill_way = '0;
  logic        rsp_valid, rsp_hit, flush_busy;
  logic [2:0]  rsp_way, rsp_victim;

  set_assoc_tag_dir i_set_assoc_tag_dir (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_ppn(lk_ppn),
    .fill_valid(fill_valid), .fill_vaddr(fill_vaddr), .fill_way(fill_way), .fill_ppn(fill_ppn),
    .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_victim(rsp_victim), .flush_busy(flush_busy));

  logic [23:0] m_tag [SETS][WAYS];
  bit          m_vld [SETS][WAYS];
  bit   [6:0]  m_plru [SETS];
  bit          m_busy, e_valid, e_hit, started;
  int          m_ptr, e_way, e_vic;
  int          vectors = 0, fails = 0, cycles = 0;
  string       cur_req = "R10";

  function automatic int pick(int s);
    int node = 0, v = 0, b;
    for (int l = 0; l < 3; l++) begin
      b = m_plru[s][node];
      v = v * 2 + b;
      node = 2 * node + 1 + b;
    end
    return v;
  endfunction

  task automatic touch(int s, int w);
    int node = 0, b;
    for (int l = 0; l < 3; l++) begin
      b = (w >> (2 - l)) & 1;
      m_plru[s][node] = (b == 0);
      node = 2 * node + 1 + b;
    end
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        m_plru[s] = '0;
        for (int w = 0; w < WAYS; w++) m_vld[s][w] = 0;
      end
      m_busy = 0; e_valid = 0; e_hit = 0;
    end else begin
      bit blk, go;
      int ls, fs;
      blk = flush || m_busy;
      ls = lk_vaddr; fs = fill_vaddr;
      go = lk_valid && !blk && !(fill_valid && fs == ls);
      e_valid = go; e_hit = 0; e_way = 0; e_vic = -1;
      if (go) begin
        for (int w = 0; w < WAYS; w++)
          if (!e_hit && m_vld[ls][w] && m_tag[ls][w] == lk_ppn) begin e_hit = 1; e_way = w; end
        for (int w = 0; w < WAYS; w++)
          if (e_vic < 0 && !m_vld[ls][w]) e_vic = w;
        if (e_vic < 0) e_vic = pick(ls);
        if (e_hit) touch(ls, e_way);
      end
      if (fill_valid && !blk) begin
        m_tag[fs][fill_way] = fill_ppn;
        m_vld[fs][fill_way] = 1;
        touch(fs, fill_way);
      end
      if (m_busy) begin
        for (int w = 0; w < WAYS; w++) m_vld[m_ptr][w] = 0;
        m_plru[m_ptr] = '0;
        m_ptr++;
        if (m_ptr == SETS) m_busy = 0;
      end else if (flush) begin
        m_busy = 1; m_ptr = 0;
      end
    end
  end

  task automatic report(string what, int act, int exp);
    fails++;
    $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, what, act, exp, $time);
  endtask

  always @(negedge clk) if (started) begin
    vectors++;
    if (rsp_valid !== e_valid) report("rsp_valid", rsp_valid, e_valid);
    if (rsp_hit !== e_hit) report("rsp_hit", rsp_hit, e_hit);
    if (flush_busy !== m_busy) report("flush_busy", flush_busy, m_busy);
    if (e_hit && rsp_way !== 3'(e_way)) report("rsp_way", rsp_way, e_way);
    if (e_valid && !e_hit && rsp_victim !== 3'(e_vic)) report("rsp_victim", rsp_victim, e_vic);
  end

  task automatic want(string what, int act, int exp);
    vectors++;
    if (act != exp) report(what, act, exp);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      cur_req = "watchdog";
      report("timeout", cycles, 100000);
      summary();
    end
  end

  task automatic step(bit lv, logic [11:0] la, logic [23:0] lt,
                      bit fv, logic [11:0] fa, int fw, logic [23:0] ft, bit fl);
    lk_valid = lv; lk_vaddr = la[11:6]; lk_ppn = lt;
    fill_valid = fv; fill_vaddr = fa[11:6]; fill_way = 3'(fw); fill_ppn = ft;
    flush = fl;
    @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic look(logic [11:0] la, logic [23:0] lt);
    step(1, la, lt, 0, 0, 0, 0, 0);
  endtask

  task automatic fill(logic [11:0] fa, int fw, logic [23:0] ft);
    step(0, 0, 0, 1, fa, fw, ft, 0);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    cur_req = "R10";
    want("reset rsp_valid", rsp_valid, 0);
    want("reset flush_busy", flush_busy, 0);
    rst_n = 1'b1;
    look(12'h0a0, 24'h080001);
    want("empty set misses", rsp_hit, 0);
    want("empty set victim", rsp_victim, 0);

    cur_req = "R1";
    fill(12'h0a0, 3, 24'h080001);
    look(12'h0a0, 24'h080001);
    want("set 2 hit", rsp_hit, 1);
    want("set 2 way", rsp_way, 3);
    look(12'h0bc, 24'h080001);
    want("same line offset hit", rsp_hit, 1);
    look(12'h0e0, 24'h080001);
    want("set 3 miss", rsp_hit, 0);

    cur_req = "R6";
    fill(12'h100, 5, 24'h00abcd);
    look(12'h100, 24'h00abcd);
    want("fill visible next cycle", rsp_hit, 1);
    want("fill way", rsp_way, 5);

    cur_req = "R3";
    look(12'h100, 24'h000001);
    want("lowest invalid victim", rsp_victim, 0);
    fill(12'h100, 0, 24'h000002);
    look(12'h100, 24'h000001);
    want("next invalid victim", rsp_victim, 1);

    cur_req = "R2";
    fill(12'h100, 6, 24'h00abcd);
    look(12'h100, 24'h00abcd);
    want("lowest matching way", rsp_way, 5);

    cur_req = "R4";
    for (int w = 0; w < 8; w++) fill(12'h140, w, 24'h000100 + 24'(w));
    look(12'h140, 24'h000fff);
    want("tree victim after ordered fills", rsp_victim, 0);
    cur_req = "R5";
    look(12'h140, 24'h000100);
    want("hit way 0", rsp_way, 0);
    look(12'h140, 24'h000fff);
    want("tree victim after touching way 0", rsp_victim, 4);
    look(12'h140, 24'h000fff);
    want("miss leaves tree", rsp_victim, 4);

    cur_req = "R7";
    step(1, 12'h240, 24'h000777, 1, 12'h240, 2, 24'h000777, 0);
    want("collided lookup dropped", rsp_valid, 0);
    look(12'h240, 24'h000777);
    want("colliding fill landed", rsp_hit, 1);

    cur_req = "R8";
    step(1, 12'h0a0, 24'h080001, 1, 12'h280, 1, 24'h000555, 0);
    want("lookup beside fill", rsp_hit, 1);
    look(12'h280, 24'h000555);
    want("fill beside lookup", rsp_hit, 1);
    step(1, 12'h2c0, 24'h000444, 1, 12'h2c0, 4, 24'h000444, 0);
    step(1, 12'h300, 24'h000444, 1, 12'h2c0, 0, 24'h000999, 0);
    want("other set miss", rsp_hit, 0);

    cur_req = "R9";
    step(1, 12'h0a0, 24'h080001, 1, 12'h0a0, 7, 24'h000123, 1);
    want("flush cycle drops lookup", rsp_valid, 0);
    want("flush busy", flush_busy, 1);
    for (int i = 0; i < 70; i++) look(12'h0a0, 24'h080001);
    want("busy ended", flush_busy, 0);
    want("flushed set misses", rsp_hit, 0);
    look(12'h0a0, 24'h000123);
    want("fill at flush ignored", rsp_hit, 0);

    cur_req = "R11";
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 999);
      step(r % 2 == 0, 12'($urandom_range(0, 3) << 6), 24'($urandom_range(0, 11)),
           r % 3 == 0, 12'($urandom_range(0, 3) << 6), $urandom_range(0, 7),
           24'($urandom_range(0, 11)), r == 7);
    end
    idle();
    summary();
  end
endmodule